// File: doc/BRIEF.md
# Strap-Polarized Link Status LED Driver

This block controls five bidirectional pads of a network physical-layer device. Each pad has two roles. While the device comes out of reset the pad is left undriven and its external pull resistor sets a level. The block samples that level once and keeps it as an address strap. After that the same pad drives an indicator LED for link speed, link integrity, duplex or collision, or traffic activity.

The strap level sampled on each pad also sets that LED's polarity. A pad pulled low gets an LED that is on when high. A pad pulled high gets an LED that is on when low. Whenever an LED is off, its pad is driven to the opposite level.

The blink rates of 10 Hz and 20 Hz are derived from a clock-frequency parameter. Short activity and collision events are stretched by hold timers, so a single-cycle event still gives a visible blink. The sampled straps are published on an 8-bit status field for a management register that lies outside this block.

Top module: `phy_led_strap`

## Requirements
- R1: While `rst_n` is low, and during the settle window after it rises, every bit of `pad_oe` is 0 and `pad_out` is 0.
- R2: `rst_n` is released through a two-stage synchronizer and then a window of SETTLE_CYC cycles follows. The pad levels are captured on the clock edge that ends this window. All five bits of `pad_oe` become 1 from that edge onward. This is the first cycle after sampling, 2+SETTLE_CYC rising edges after `rst_n` rises.
- R3: `strap_status` bits 7, 6, 5, 4 and 3 hold the sampled levels of pads 4, 3, 2, 1 and 0. Bits 2 to 0 are 0. The field does not change again until the next reset, whatever `pad_in` does later.
- R4: A pad that sampled 0 drives 1 when its LED is on. A pad that sampled 1 drives 0 when its LED is on. An LED that is off drives the inverse of its on level, which equals its sampled strap.
- R5: Pad 2 is on while `link_good` is 1. Pad 4 is on while `link_good`=1 and `speed_100`=0 (10 Mb/s). Pad 0 is on while `link_good`=1 and `speed_100`=1 (100 Mb/s).
- R6: While `full_duplex`=1, pad 1 is steadily on whatever `collision` does.
- R7: While `full_duplex`=0 and the collision hold is active, pad 1 blinks at 20 Hz: it changes level every CLK_HZ/40 cycles.
- R8: While the activity hold is active, pad 3 blinks at 10 Hz: it changes level every CLK_HZ/20 cycles.
- R9: Each cycle with `activity`=1 retriggers a hold of CLK_HZ/10 cycles, one 10 Hz period. Each cycle with `collision`=1 retriggers a hold of CLK_HZ/20 cycles, one 20 Hz period. A single-cycle event therefore gives exactly half a hold of on time, and the LED is off once the hold has run out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock at CLK_HZ |
| rst_n | input | 1 | Asynchronous active-low reset |
| pad_in | input | 5 | Levels read back from the five pads |
| pad_out | output | 5 | Output values for the five pads |
| pad_oe | output | 5 | Output enables for the five pads, 1 = drive |
| link_good | input | 1 | Link integrity is good |
| speed_100 | input | 1 | 1 = 100 Mb/s, 0 = 10 Mb/s |
| full_duplex | input | 1 | 1 = full duplex, 0 = half duplex |
| collision | input | 1 | Collision event, one per cycle |
| activity | input | 1 | Transmit or receive event, one per cycle |
| strap_status | output | 8 | Sampled strap levels in bits 7..3 |

## Verification
The bench applies two opposite strap patterns. A design that ignored the strap polarity, or inverted it, drives every off LED to the wrong level and fails both the idle checks and the lit checks. It checks the exact edge on which the enables rise, so an early enable, which would fight the strap resistors, or a late one is caught. It also changes `pad_in` after sampling to show that the status field stays frozen.

It measures blink half-periods to the cycle and asserts collision during full duplex, which must leave pad 1 steady. It counts the lit cycles produced by a single-cycle event. A hold timer that was too short, was not retriggered, or never ran out gives a count other than half the hold, or leaves the LED lit afterwards.

// File: rtl/phy_led_pkg.sv
package phy_led_pkg;
  localparam int NUM_PADS = 5;
  localparam int STATUS_W = 8;
  localparam int STATUS_LSB = 3;

  localparam int PAD_SPD10 = 4;
  localparam int PAD_ACT   = 3;
  localparam int PAD_LINK  = 2;
  localparam int PAD_DPX   = 1;
  localparam int PAD_SPD100 = 0;

  typedef enum logic {
    PH_SETTLE = 1'b0,
    PH_RUN    = 1'b1
  } pad_phase_e;
endpackage

// File: rtl/led_blink_prescaler.sv
module led_blink_prescaler #(
  parameter int HALF_CYC = 100
) (
  input  logic clk,
  input  logic rst_n,
  output logic blink
);
  localparam int CW = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;
  localparam logic [CW-1:0] LAST = CW'(HALF_CYC - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          blink_q, blink_d;
  logic          wrap;

  always_comb begin
    wrap    = (cnt_q == LAST);
    cnt_d   = wrap ? '0 : cnt_q + 1'b1;
    blink_d = wrap ? ~blink_q : blink_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      blink_q <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      blink_q <= blink_d;
    end
  end

  assign blink = blink_q;
endmodule

// File: rtl/led_event_hold.sv
module led_event_hold #(
  parameter int HOLD_CYC = 200
) (
  input  logic clk,
  input  logic rst_n,
  input  logic event_in,
  output logic hold_active
);
  localparam int CW = $clog2(HOLD_CYC + 1);
  localparam logic [CW-1:0] LOAD = CW'(HOLD_CYC);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = event_in || (cnt_q != '0);
    if (event_in) cnt_d = LOAD;
    else          cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign hold_active = (cnt_q != '0);
endmodule

// File: rtl/led_strap_ctrl.sv
module led_strap_ctrl
  import phy_led_pkg::*;
#(
  parameter int SETTLE_CYC = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PADS-1:0] pad_in,
  output logic                run,
  output logic [NUM_PADS-1:0] strap
);
  localparam int CW = (SETTLE_CYC > 1) ? $clog2(SETTLE_CYC) : 1;
  localparam logic [CW-1:0] LAST = CW'(SETTLE_CYC - 1);

  pad_phase_e          phase_q, phase_d;
  logic [CW-1:0]       cnt_q, cnt_d;
  logic [NUM_PADS-1:0] strap_q;
  logic                capture;

  always_comb begin
    phase_d = phase_q;
    cnt_d   = cnt_q;
    capture = 1'b0;
    if (phase_q == PH_SETTLE) begin
      if (cnt_q == LAST) begin
        capture = 1'b1;
        phase_d = PH_RUN;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_SETTLE;
      cnt_q   <= '0;
    end else begin
      phase_q <= phase_d;
      cnt_q   <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       strap_q <= '0;
    else if (capture) strap_q <= pad_in;
  end

  assign run   = (phase_q == PH_RUN);
  assign strap = strap_q;
endmodule

// File: rtl/phy_led_strap.sv
module phy_led_strap
  import phy_led_pkg::*;
#(
  parameter int CLK_HZ     = 50_000_000,
  parameter int SETTLE_CYC = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PADS-1:0] pad_in,
  output logic [NUM_PADS-1:0] pad_out,
  output logic [NUM_PADS-1:0] pad_oe,
  input  logic                link_good,
  input  logic                speed_100,
  input  logic                full_duplex,
  input  logic                collision,
  input  logic                activity,
  output logic [STATUS_W-1:0] strap_status
);
  localparam int HALF_10 = CLK_HZ / 20;
  localparam int HALF_20 = CLK_HZ / 40;
  localparam int HOLD_ACT = 2 * HALF_10;
  localparam int HOLD_COL = 2 * HALF_20;

  logic rst_meta_q, rst_sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  logic                run;
  logic [NUM_PADS-1:0] strap;
  logic                blink10, blink20;
  logic                act_hold, col_hold;
  logic [NUM_PADS-1:0] led_on;

  led_strap_ctrl #(.SETTLE_CYC(SETTLE_CYC)) u_strap (
    .clk    (clk),
    .rst_n  (rst_sync_q),
    .pad_in (pad_in),
    .run    (run),
    .strap  (strap)
  );

  led_blink_prescaler #(.HALF_CYC(HALF_10)) u_blink10 (
    .clk   (clk),
    .rst_n (rst_sync_q),
    .blink (blink10)
  );

  led_blink_prescaler #(.HALF_CYC(HALF_20)) u_blink20 (
    .clk   (clk),
    .rst_n (rst_sync_q),
    .blink (blink20)
  );

  led_event_hold #(.HOLD_CYC(HOLD_ACT)) u_act_hold (
    .clk         (clk),
    .rst_n       (rst_sync_q),
    .event_in    (activity),
    .hold_active (act_hold)
  );

  led_event_hold #(.HOLD_CYC(HOLD_COL)) u_col_hold (
    .clk         (clk),
    .rst_n       (rst_sync_q),
    .event_in    (collision),
    .hold_active (col_hold)
  );

  always_comb begin
    led_on              = '0;
    led_on[PAD_SPD10]   = link_good && !speed_100;
    led_on[PAD_SPD100]  = link_good && speed_100;
    led_on[PAD_LINK]    = link_good;
    led_on[PAD_ACT]     = act_hold && blink10;
    led_on[PAD_DPX]     = full_duplex || (col_hold && blink20);
  end

  genvar gi;
  generate
    for (gi = 0; gi < NUM_PADS; gi++) begin : g_pad
      assign pad_oe[gi]  = run;
      assign pad_out[gi] = run ? (led_on[gi] ^ strap[gi]) : 1'b0;
      assign strap_status[STATUS_LSB + gi] = strap[gi];
    end
    if (STATUS_LSB > 0) begin : g_low
      assign strap_status[STATUS_LSB-1:0] = '0;
    end
  endgenerate
endmodule

// File: rtl/phy_led_strap_chk.sv
module phy_led_strap_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [4:0] pad_out,
  input logic [4:0] pad_oe,
  input logic       link_good,
  input logic       full_duplex,
  input logic [7:0] strap_status
);
  a_r1_undriven_in_reset: assert property (@(posedge clk)
    !rst_n |-> (pad_oe == 5'b0));

  a_r1_zero_when_released: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_oe == 5'b0) |-> (pad_out == 5'b0));

  a_r2_enables_together: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_oe == 5'b0) || (pad_oe == 5'b11111));

  a_r2_enable_sticks: assert property (@(posedge clk) disable iff (!rst_n)
    pad_oe[0] |=> pad_oe[0]);

  a_r3_status_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    pad_oe[0] |=> $stable(strap_status));

  a_r3_low_bits_zero: assert property (@(posedge clk) disable iff (!rst_n)
    strap_status[2:0] == 3'b0);

  a_r4_off_level: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_oe[0] && !link_good) |->
      (pad_out[4] == strap_status[7] && pad_out[2] == strap_status[5] &&
       pad_out[0] == strap_status[3]));

  a_r5_one_speed: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_oe[0] && link_good) |->
      ((pad_out[4] ^ strap_status[7]) != (pad_out[0] ^ strap_status[3])));

  a_r6_duplex_steady: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_oe[0] && full_duplex) |-> (pad_out[1] != strap_status[4]));
endmodule

bind phy_led_strap phy_led_strap_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .pad_out      (pad_out),
  .pad_oe       (pad_oe),
  .link_good    (link_good),
  .full_duplex  (full_duplex),
  .strap_status (strap_status)
);

// File: tb/test_phy_led_strap.sv
module test_phy_led_strap;
  localparam int CLK_HZ = 4000;
  localparam int SETTLE = 8;
  localparam int HALF10 = CLK_HZ / 20;
  localparam int HALF20 = CLK_HZ / 40;

  logic       clk;
  logic       rst_n;
  logic [4:0] pad_in;
  logic [4:0] pad_out;
  logic [4:0] pad_oe;
  logic       link_good, speed_100, full_duplex, collision, activity;
  logic [7:0] strap_status;

  int n_cmp;
  int n_bad;

  phy_led_strap #(.CLK_HZ(CLK_HZ), .SETTLE_CYC(SETTLE)) i_phy_led_strap (
    .clk          (clk),
    .rst_n        (rst_n),
    .pad_in       (pad_in),
    .pad_out      (pad_out),
    .pad_oe       (pad_oe),
    .link_good    (link_good),
    .speed_100    (speed_100),
    .full_duplex  (full_duplex),
    .collision    (collision),
    .activity     (activity),
    .strap_status (strap_status)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic t_reset(input logic [4:0] s);
    link_good = 0; speed_100 = 0; full_duplex = 0; collision = 0; activity = 0;
    @(negedge clk);
    rst_n = 1'b0;
    pad_in = s;
    cyc(3);
    check("R1 oe in reset", pad_oe, 5'b0);
    check("R1 out in reset", pad_out, 5'b0);
    rst_n = 1'b1;
    cyc(1 + SETTLE);
    check("R1 oe in settle", pad_oe, 5'b0);
    check("R1 out in settle", pad_out, 5'b0);
    cyc(1);
    check("R2 oe after sample", pad_oe, 5'b11111);
    check("R3 status field", strap_status, {s, 3'b000});
    pad_in = ~s;
    cyc(5);
    check("R3 status frozen", strap_status, {s, 3'b000});
  endtask

  task automatic t_static(input logic [4:0] s);
    link_good = 0; speed_100 = 0; full_duplex = 0;
    cyc(1);
    check("R4 idle inactive level", pad_out, s);
    link_good = 1; speed_100 = 1; full_duplex = 1;
    cyc(1);
    check("R5 100M full", pad_out, s ^ 5'b00111);
    speed_100 = 0; full_duplex = 0;
    cyc(1);
    check("R5 10M half", pad_out, s ^ 5'b10100);
    link_good = 0;
    cyc(1);
    check("R5 link down", pad_out, s);
  endtask

  task automatic t_duplex(input logic [4:0] s);
    int bad = 0;
    full_duplex = 1; collision = 1;
    for (int i = 0; i < 3 * HALF20; i++) begin
      @(negedge clk);
      if (pad_out[1] !== ~s[1]) bad++;
    end
    check("R6 full duplex steady with collision", bad, 0);
    collision = 0; full_duplex = 0;
  endtask

  task automatic measure(input int bit_i, output int gap);
    logic prev;
    int guard = 0;
    @(negedge clk);
    prev = pad_out[bit_i];
    while (pad_out[bit_i] === prev && guard < 2000) begin @(negedge clk); guard++; end
    prev = pad_out[bit_i];
    gap = 0;
    while (pad_out[bit_i] === prev && gap < 2000) begin @(negedge clk); gap++; end
  endtask

  task automatic t_collision();
    int gap;
    full_duplex = 0; collision = 1;
    measure(1, gap);
    check("R7 collision half period", gap, HALF20);
    collision = 0;
  endtask

  task automatic t_activity();
    int gap;
    activity = 1;
    measure(3, gap);
    check("R8 activity half period", gap, HALF10);
    activity = 0;
  endtask

  task automatic t_pulse(input logic [4:0] s);
    int on_act = 0, on_col = 0;
    cyc(3 * HALF10);
    activity = 1; collision = 1;
    @(negedge clk);
    activity = 0; collision = 0;
    for (int i = 0; i < 4 * HALF10 + 50; i++) begin
      if (pad_out[3] === ~s[3]) on_act++;
      if (pad_out[1] === ~s[1]) on_col++;
      @(negedge clk);
    end
    check("R9 activity pulse on cycles", on_act, HALF10);
    check("R9 collision pulse on cycles", on_col, HALF20);
    check("R9 activity off after hold", pad_out[3], s[3]);
    check("R9 collision off after hold", pad_out[1], s[1]);
  endtask

  task automatic run_all(input logic [4:0] s);
    t_reset(s);
    t_static(s);
    t_duplex(s);
    t_collision();
    t_activity();
    t_pulse(s);
  endtask

  initial begin
    n_cmp = 0; n_bad = 0;
    rst_n = 1'b0;
    pad_in = 5'b0;
    link_good = 0; speed_100 = 0; full_duplex = 0; collision = 0; activity = 0;
    run_all(5'b10110);
    run_all(5'b01001);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(20 * 100000);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule